// File: doc/BRIEF.md
# I2C Master Transmit Queue with NAK Halt

This block is the byte-level transmit path of an I2C master. Software-side register writes place bytes into a 64-entry queue. The block hands the bytes one at a time to a bit engine over a valid/ready handshake. It then waits for the engine's acknowledge result before it offers the next byte. The bit-level waveform generation and the receive path belong to other blocks.

When the target answers with a NAK, the block stops. It raises a NAK status flag and shows a sticky acknowledge-failure bit. It offers no further bytes until a queue-control write flushes the leftover bytes. Separately, a drained flag is raised once the last queued byte's acknowledge slot has completed. Each status flag can be routed to the interrupt line through its own enable bit.

Top module: `i2c_txq`

## Requirements
- R1: After reset the queue is disabled and holds 0 bytes. `q_stat` bit 4 (queue empty) is 1. `int_stat`, `irq`, `tx_valid` and `ack_fail` are all 0.
- R2: While the queue enable (control bit 6) is 0, data writes are dropped and no byte is offered to the bit engine.
- R3: Bytes are offered in write order. `tx_valid` stays high with a stable `tx_byte` until `tx_ready`. No further byte is offered until `ack_valid` returns a result for the current one.
- R4: The queue holds 64 bytes. A data write while it is full is dropped, and the stored bytes are still sent intact.
- R5: `q_stat` bit 4 reads 1 only when the queue is empty and no byte is being offered or awaiting its acknowledge. Leaving the queue is not enough.
- R6: An ACK result that leaves the queue empty sets `int_stat` bit 1 (drained).
- R7: A NAK result sets `int_stat` bit 0 and `ack_fail`. After that, no byte is offered even if bytes remain queued.
- R8: A control write with bit 7 set empties the queue, clears `ack_fail` and aborts any byte in flight. Bit 6 of the same write sets the new enable value.
- R9: Writing 1 to a status bit clears it, but a new event in the same cycle wins. `irq` is the OR of `int_stat` ANDed with `int_en` (bit 1 drained, bit 0 NAK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat_we | input | 1 | Data register write strobe |
| dat_wd | input | 8 | Byte to queue |
| ctl_we | input | 1 | Queue control write strobe |
| ctl_wd | input | 8 | Bit 7 flush, bit 6 enable |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wd | input | 8 | Bit 1 drained enable, bit 0 NAK enable |
| sclr_we | input | 1 | Status clear write strobe |
| sclr_wd | input | 8 | Write 1 to clear: bit 1 drained, bit 0 NAK |
| tx_valid | output | 1 | Byte offered to bit engine |
| tx_byte | output | 8 | Offered byte |
| tx_ready | input | 1 | Bit engine takes the byte |
| ack_valid | input | 1 | Acknowledge result strobe |
| ack_nak | input | 1 | 1 when the target did not acknowledge |
| int_stat | output | 2 | Sticky status: bit 1 drained, bit 0 NAK |
| int_en | output | 2 | Current interrupt enables |
| q_stat | output | 8 | Queue status, bit 4 empty, other bits 0 |
| ack_fail | output | 1 | Acknowledge-failure bit, 1 after NAK until flush |
| q_level | output | 7 | Bytes stored |
| irq | output | 1 | Interrupt request |

## Verification
Every register write lands on the next clock edge. `q_level`, the enable and `ack_fail` are therefore visible one cycle after the strobe. A byte written to an idle, enabled queue is offered on `tx_valid` one further cycle later, because the sequencer registers its state. `int_stat`, `ack_fail` and the empty bit change on the same edge that samples `ack_valid`. `irq` follows `int_stat` combinationally. The bench drives inputs and samples outputs on falling edges, so each check reads a value that is one or two edges after its cause. A bit-engine model compares each accepted byte against the scoreboard queue at the handshake edge. It also confirms that nothing is offered while the acknowledge is outstanding.

// File: rtl/i2c_txq_pkg.sv
package i2c_txq_pkg;
   localparam int CTL_FLUSH_BIT = 7;
   localparam int CTL_EN_BIT    = 6;
   localparam int ST_DRAIN_BIT  = 1;
   localparam int ST_NAK_BIT    = 0;
   localparam int QS_EMPTY_BIT  = 4;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_OFFER = 2'd1,
      SQ_WAIT = 2'd2,
      SQ_HALT = 2'd3
   } sq_state_t;
endpackage

// File: rtl/i2c_txq_store.sv
module i2c_txq_store #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] push_d,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          full,
   output logic          empty,
   output logic [LW-1:0] level
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign head    = mem[rp];

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      logic [AW-1:0] r;
      if ((DEPTH & (DEPTH - 1)) == 0) r = p + 1'b1;
      else r = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
      return r;
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
         level <= '0;
      end else if (flush) begin
         wp <= '0;
         rp <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= nxt(wp);
         if (do_pop) rp <= nxt(rp);
         case ({do_push, do_pop})
            2'b10: level <= level + 1'b1;
            2'b01: level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/i2c_txq_seq.sv
module i2c_txq_seq
   import i2c_txq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic q_en,
   input  logic q_empty,
   input  logic tx_ready,
   input  logic ack_valid,
   input  logic ack_nak,
   output logic tx_valid,
   output logic pop,
   output logic busy,
   output logic halted,
   output logic ev_drain,
   output logic ev_nak
);
   sq_state_t st, st_n;

   assign tx_valid = (st == SQ_OFFER);
   assign pop      = tx_valid && tx_ready && !flush;
   assign busy     = (st == SQ_OFFER) || (st == SQ_WAIT);
   assign halted   = (st == SQ_HALT);
   assign ev_nak   = (st == SQ_WAIT) && ack_valid && ack_nak && !flush;
   assign ev_drain = (st == SQ_WAIT) && ack_valid && !ack_nak && q_empty && !flush;

   always_comb begin
      st_n = st;
      unique case (st)
         SQ_IDLE:  if (q_en && !q_empty) st_n = SQ_OFFER;
         SQ_OFFER: if (tx_ready) st_n = SQ_WAIT;
         SQ_WAIT:  if (ack_valid) st_n = ack_nak ? SQ_HALT : SQ_IDLE;
         SQ_HALT:  st_n = SQ_HALT;
         default:  st_n = SQ_IDLE;
      endcase
      if (flush) st_n = SQ_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SQ_IDLE;
      else st <= st_n;
   end
endmodule

// File: rtl/i2c_txq_irq.sv
module i2c_txq_irq #(
   parameter int NFLAG = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set_ev,
   input  logic             clr_we,
   input  logic [NFLAG-1:0] clr_wd,
   input  logic             en_we,
   input  logic [NFLAG-1:0] en_wd,
   output logic [NFLAG-1:0] stat,
   output logic [NFLAG-1:0] en,
   output logic             irq
);
   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat[i] <= 1'b0;
            en[i]   <= 1'b0;
         end else begin
            if (set_ev[i]) stat[i] <= 1'b1;
            else if (clr_we && clr_wd[i]) stat[i] <= 1'b0;
            if (en_we) en[i] <= en_wd[i];
         end
      end
   end
   assign irq = |(stat & en);
endmodule

// File: rtl/i2c_txq.sv
module i2c_txq
   import i2c_txq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dat_we,
   input  logic [7:0]    dat_wd,
   input  logic          ctl_we,
   input  logic [7:0]    ctl_wd,
   input  logic          ien_we,
   input  logic [7:0]    ien_wd,
   input  logic          sclr_we,
   input  logic [7:0]    sclr_wd,
   output logic          tx_valid,
   output logic [7:0]    tx_byte,
   input  logic          tx_ready,
   input  logic          ack_valid,
   input  logic          ack_nak,
   output logic [1:0]    int_stat,
   output logic [1:0]    int_en,
   output logic [7:0]    q_stat,
   output logic          ack_fail,
   output logic [LW-1:0] q_level,
   output logic          irq
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("i2c_txq: DEPTH must be at least 2");
   end

   logic q_en, flush, q_full, q_empty, pop, busy, ev_drain, ev_nak;
   logic [1:0] ev;

   assign flush = ctl_we && ctl_wd[CTL_FLUSH_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_en <= 1'b0;
      else if (ctl_we) q_en <= ctl_wd[CTL_EN_BIT];
   end

   i2c_txq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(dat_we && q_en), .push_d(dat_wd), .pop(pop),
      .head(tx_byte), .full(q_full), .empty(q_empty), .level(q_level)
   );

   i2c_txq_seq u_seq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .q_en(q_en),
      .q_empty(q_empty), .tx_ready(tx_ready), .ack_valid(ack_valid),
      .ack_nak(ack_nak), .tx_valid(tx_valid), .pop(pop), .busy(busy),
      .halted(ack_fail), .ev_drain(ev_drain), .ev_nak(ev_nak)
   );

   always_comb begin
      ev = '0;
      ev[ST_DRAIN_BIT] = ev_drain;
      ev[ST_NAK_BIT]   = ev_nak;
   end

   i2c_txq_irq #(.NFLAG(2)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_ev(ev),
      .clr_we(sclr_we), .clr_wd(sclr_wd[1:0]),
      .en_we(ien_we), .en_wd(ien_wd[1:0]),
      .stat(int_stat), .en(int_en), .irq(irq)
   );

   always_comb begin
      q_stat = '0;
      q_stat[QS_EMPTY_BIT] = q_empty && !busy;
   end

   logic unused_full;
   assign unused_full = q_full;
endmodule

// File: rtl/i2c_txq_chk.sv
module i2c_txq_chk #(
   parameter int DEPTH = 64,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctl_we,
   input logic [7:0]    ctl_wd,
   input logic          tx_valid,
   input logic [7:0]    tx_byte,
   input logic          tx_ready,
   input logic [1:0]    int_stat,
   input logic [7:0]    q_stat,
   input logic          ack_fail,
   input logic [LW-1:0] q_level
);
   logic fl;
   assign fl = ctl_we && ctl_wd[7];

   AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !fl |=> tx_valid && $stable(tx_byte)) else $error("hold"); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (q_level == LW'(DEPTH)) && !(tx_valid && tx_ready) && !fl |=> q_level == LW'(DEPTH)) else $error("ovf"); // R4
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      q_level <= LW'(DEPTH)) else $error("bound"); // R4
   AST_EMPTY_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !q_stat[4]) else $error("empty"); // R5
   AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fail |-> !tx_valid) else $error("halt"); // R7
   AST_NAK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_fail) |-> int_stat[0]) else $error("nakflag"); // R7
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      fl |=> (q_level == '0) && !ack_fail && !tx_valid) else $error("flush"); // R8
endmodule

bind i2c_txq i2c_txq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wd(ctl_wd),
   .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
   .int_stat(int_stat), .q_stat(q_stat), .ack_fail(ack_fail), .q_level(q_level)
);

// File: tb/i2c_txq_tb.sv
module i2c_txq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic dat_we = 0, ctl_we = 0, ien_we = 0, sclr_we = 0;
   logic [7:0] dat_wd = 0, ctl_wd = 0, ien_wd = 0, sclr_wd = 0;
   logic tx_valid, tx_ready = 0, ack_valid = 0, ack_nak = 0, ack_fail, irq;
   logic [7:0] tx_byte, q_stat;
   logic [1:0] int_stat, int_en;
   logic [6:0] q_level;

   int n_chk = 0, n_fail = 0;
   int sent = 0, nak_at = -1;
   bit hold = 0;
   byte unsigned expq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_txq #(.DEPTH(DEPTH)) dut_i (.*);

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input int which, input logic [7:0] v);
      @(negedge clk);
      case (which)
         0: begin dat_we = 1; dat_wd = v; end
         1: begin ctl_we = 1; ctl_wd = v; end
         2: begin ien_we = 1; ien_wd = v; end
         default: begin sclr_we = 1; sclr_wd = v; end
      endcase
      @(negedge clk);
      dat_we = 0; ctl_we = 0; ien_we = 0; sclr_we = 0;
   endtask

   task automatic push_byte(input logic [7:0] v, input bit expect_it);
      if (expect_it) expq.push_back(v);
      wr(0, v);
   endtask

   // bit engine model and scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (tx_valid && !hold && rst_n) begin
            tx_ready = 1;
            chk("R5 empty low while offering", q_stat[4], 0);
            if (expq.size() == 0) chk("R3 unexpected byte", tx_byte, 'hFFFF);
            else chk("R3 byte order", tx_byte, expq.pop_front());
            @(negedge clk);
            tx_ready = 0;
            repeat (2) begin
               chk("R3 no offer before ack", tx_valid, 0);
               @(negedge clk);
            end
            ack_valid = 1;
            ack_nak = (sent == nak_at);
            @(negedge clk);
            ack_valid = 0;
            ack_nak = 0;
            sent++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 empty bit", q_stat, 8'h10);
      chk("R1 status", int_stat, 0);
      chk("R1 irq/valid/fail", {irq, tx_valid, ack_fail}, 0);
      chk("R1 level", q_level, 0);

      push_byte(8'h11, 0);
      repeat (4) @(negedge clk);
      chk("R2 disabled drop level", q_level, 0);
      chk("R2 disabled no offer", tx_valid, 0);

      wr(1, 8'h80);              // flush, enable stays 0
      push_byte(8'h12, 0);
      chk("R8 enable from bit6=0", q_level, 0);

      wr(1, 8'hC0);
      wr(2, 8'h03);
      for (int i = 0; i < 5; i++) push_byte(8'hA0 + 8'(i), 1);
      wait (int_stat[1]);
      @(negedge clk);
      chk("R6 drained set", int_stat, 2'b10);
      chk("R9 irq on drained", irq, 1);
      chk("R5 empty after last ack", q_stat[4], 1);
      chk("R3 all sent", expq.size(), 0);
      wr(3, 8'h02);
      chk("R9 clear drained", {int_stat, irq}, 0);

      nak_at = sent + 1;
      for (int i = 0; i < 4; i++) push_byte(8'hB0 + 8'(i), i < 2);
      wait (int_stat[0]);
      repeat (20) @(negedge clk);
      chk("R7 nak flag", int_stat, 2'b01);
      chk("R7 ack fail bit", ack_fail, 1);
      chk("R7 halt keeps bytes", q_level, 2);
      chk("R7 no offer after nak", tx_valid, 0);
      chk("R9 irq on nak", irq, 1);
      chk("R5 empty low with bytes", q_stat[4], 0);
      wr(1, 8'hC0);
      chk("R8 flush level", q_level, 0);
      chk("R8 flush clears fail", ack_fail, 0);
      chk("R8 empty after flush", q_stat[4], 1);
      wr(3, 8'h03);
      chk("R9 clear nak", {int_stat, irq}, 0);
      nak_at = -1;

      hold = 1;
      for (int i = 0; i < DEPTH + 2; i++) push_byte(8'(i * 3 + 1), i < DEPTH);
      chk("R4 full level", q_level, DEPTH);
      hold = 0;
      wait (int_stat[1]);
      @(negedge clk);
      chk("R4 overflow dropped", expq.size(), 0);
      chk("R5 empty at end", q_stat[4], 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule